// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is one DMA channel engine. It issues a stream of word-transfer addresses toward the memory path, so data moves while the processor keeps running. Software starts the channel by writing a control block in a single cycle. The control block holds a start address, a signed stride, a word count and a link pointer. For each accepted word the engine advances the address by the stride and lowers the count. When a block finishes, the engine raises a one-cycle interrupt. If the link pointer is nonzero, the engine then reads a fresh control block from memory and carries on by itself.

The channel can also be paced by an external peripheral that is not synchronous to the chip clock. That peripheral's request line passes through a two-flop synchronizer. Each rising edge of the synchronized request earns the channel permission to move one word, and the grant output is high while such a word is on offer. A channel that is not paced ignores the request line.

Top module: `dma_chain_ctrl`

## Requirements
- R1: After reset, active_o, xfer_valid_o, dma_gnt_o, desc_rd_o and irq_o are all low.
- R2: A cb_wr_i pulse while the channel is idle starts it. On the next cycle active_o is high and xfer_addr_o equals the written start address.
- R3: Each accepted word (xfer_valid_o and xfer_ready_i both high) advances xfer_addr_o by the signed stride, taken as a two's complement value. A block ends after exactly as many accepted words as its count.
- R4: A block whose count is zero moves no word but still ends normally, including its interrupt.
- R5: A cb_wr_i pulse while active_o is high is ignored: the running transfer keeps its addresses and word count.
- R6: irq_o is a one-cycle pulse raised after a block ends. With irq-every set, a pulse is raised for each block. With irq-every clear, a pulse is raised only for the block whose link is zero.
- R7: A nonzero link makes the channel read four words at link+0, link+1, link+2 and link+3, in that order. These words are the start address, the stride, the count and the next link. The channel then runs that block.
- R8: A block whose link is zero ends the chain, and active_o falls.
- R9: In paced mode, no word is offered without credit. Each synchronized rising edge of dma_req_i, seen while the channel is active, grants exactly one word, and dma_gnt_o is high while that word is on offer. Edges that arrive while earlier words wait for acceptance are not lost.
- R10: In unpaced mode, dma_req_i has no effect and dma_gnt_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cb_wr_i | input | 1 | Control block write strobe |
| cb_addr_i | input | AW | Start address |
| cb_mod_i | input | AW | Signed stride |
| cb_cnt_i | input | AW | Word count |
| cb_next_i | input | AW | Link pointer, zero ends the chain |
| cb_paced_i | input | 1 | Pace words by the external request |
| cb_irq_every_i | input | 1 | Interrupt at every block, not only at chain end |
| active_o | output | 1 | Channel busy |
| xfer_valid_o | output | 1 | Word transfer offered |
| xfer_addr_o | output | AW | Word address |
| xfer_ready_i | input | 1 | Word accepted |
| dma_req_i | input | 1 | Asynchronous peripheral request |
| dma_gnt_o | output | 1 | Grant to peripheral |
| desc_rd_o | output | 1 | Control block word read |
| desc_addr_o | output | AW | Control block word address |
| desc_ack_i | input | 1 | Read data valid |
| desc_data_i | input | AW | Read data |
| irq_o | output | 1 | Block completion pulse |

## Verification
In paced mode a synchronized request edge can fall in the same cycle in which an earlier granted word is accepted. Lost or duplicated credit would show up as a wrong word total. The bench provokes this in two ways. First, it holds xfer_ready_i low while several request pulses arrive and then releases it. Second, it toggles dma_req_i every two cycles with ready held high, so that edges and acceptances overlap. Each run is judged by the exact number of accepted words, by dma_gnt_o being high at every acceptance, and by a single completion pulse.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_FETCH = 2'd2
  } dma_state_e;

  // control block word order in memory, relative to the link pointer
  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_MOD  = 2'd1;
  localparam logic [1:0] FLD_CNT  = 2'd2;
  localparam logic [1:0] FLD_NEXT = 2'd3;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int CRW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic arm_i,
  input  logic take_i,
  output logic avail_o
);
  localparam logic [CRW-1:0] CRED_MAX = {CRW{1'b1}};

  logic [2:0]     sync_q;
  logic [CRW-1:0] cred_q;
  logic           rise, inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], req_i};
  end

  assign rise    = sync_q[1] & ~sync_q[2];
  assign inc     = rise && (cred_q != CRED_MAX);
  assign avail_o = (cred_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cred_q <= '0;
    else if (!arm_i)  cred_q <= '0;
    else if (inc && !take_i) cred_q <= cred_q + 1'b1;
    else if (!inc && take_i) cred_q <= cred_q - 1'b1;
  end

  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> cred_q != '0);
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [AW-1:0] ld_mod_i,
  input  logic [AW-1:0] ld_cnt_i,
  input  logic [AW-1:0] ld_next_i,
  input  logic          fwr_i,
  input  logic [1:0]    fsel_i,
  input  logic [AW-1:0] fdata_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] next_o,
  output logic          cnt_zero_o
);
  import dma_chan_pkg::*;

  logic [AW-1:0] addr_q, mod_q, cnt_q, next_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0; mod_q <= '0; cnt_q <= '0; next_q <= '0;
    end else if (load_i) begin
      addr_q <= ld_addr_i; mod_q <= ld_mod_i;
      cnt_q  <= ld_cnt_i;  next_q <= ld_next_i;
    end else if (fwr_i) begin
      case (fsel_i)
        FLD_ADDR: addr_q <= fdata_i;
        FLD_MOD:  mod_q  <= fdata_i;
        FLD_CNT:  cnt_q  <= fdata_i;
        default:  next_q <= fdata_i;
      endcase
    end else if (step_i) begin
      addr_q <= addr_q + mod_q;  // two's complement stride
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign addr_o     = addr_q;
  assign next_o     = next_q;
  assign cnt_zero_o = (cnt_q == '0);

  assert_no_step_past_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !cnt_zero_o);
  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i && !fwr_i) |=> $stable(addr_o));
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_end_i,
  input  logic last_i,
  input  logic every_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= blk_end_i && (every_i || last_i);
  end

  assign irq_o = irq_q;

  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/dma_chain_ctrl.sv
module dma_chain_ctrl #(
  parameter int AW  = 32,
  parameter int CRW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cb_wr_i,
  input  logic [AW-1:0] cb_addr_i,
  input  logic [AW-1:0] cb_mod_i,
  input  logic [AW-1:0] cb_cnt_i,
  input  logic [AW-1:0] cb_next_i,
  input  logic          cb_paced_i,
  input  logic          cb_irq_every_i,
  output logic          active_o,
  output logic          xfer_valid_o,
  output logic [AW-1:0] xfer_addr_o,
  input  logic          xfer_ready_i,
  input  logic          dma_req_i,
  output logic          dma_gnt_o,
  output logic          desc_rd_o,
  output logic [AW-1:0] desc_addr_o,
  input  logic          desc_ack_i,
  input  logic [AW-1:0] desc_data_i,
  output logic          irq_o
);
  import dma_chan_pkg::*;

  dma_state_e    state_q;
  logic          paced_q, every_q;
  logic [1:0]    fidx_q;
  logic          load, cnt_zero, blk_end, chain_last, avail, step, fwr;
  logic [AW-1:0] next_ptr;

  assign load       = cb_wr_i && (state_q == ST_IDLE);
  assign blk_end    = (state_q == ST_XFER) && cnt_zero;
  assign chain_last = (next_ptr == '0);
  assign xfer_valid_o = (state_q == ST_XFER) && !cnt_zero && (!paced_q || avail);
  assign step       = xfer_valid_o && xfer_ready_i;
  assign dma_gnt_o  = paced_q && xfer_valid_o;
  assign desc_rd_o  = (state_q == ST_FETCH);
  assign desc_addr_o = next_ptr + AW'(fidx_q);
  assign fwr        = desc_rd_o && desc_ack_i;
  assign active_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      paced_q <= 1'b0;
      every_q <= 1'b0;
      fidx_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load) begin
          state_q <= ST_XFER;
          paced_q <= cb_paced_i;
          every_q <= cb_irq_every_i;
        end
        ST_XFER: if (blk_end) begin
          fidx_q  <= '0;
          state_q <= chain_last ? ST_IDLE : ST_FETCH;
        end
        ST_FETCH: if (fwr) begin
          fidx_q <= fidx_q + 1'b1;
          if (fidx_q == FLD_NEXT) state_q <= ST_XFER;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dma_req_sync #(.CRW(CRW)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (dma_req_i),
    .arm_i   (active_o && paced_q),
    .take_i  (step && paced_q),
    .avail_o (avail)
  );

  dma_addr_cnt #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .ld_addr_i  (cb_addr_i),
    .ld_mod_i   (cb_mod_i),
    .ld_cnt_i   (cb_cnt_i),
    .ld_next_i  (cb_next_i),
    .fwr_i      (fwr),
    .fsel_i     (fidx_q),
    .fdata_i    (desc_data_i),
    .step_i     (step),
    .addr_o     (xfer_addr_o),
    .next_o     (next_ptr),
    .cnt_zero_o (cnt_zero)
  );

  dma_irq_gen u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blk_end_i (blk_end),
    .last_i    (chain_last),
    .every_i   (every_q),
    .irq_o     (irq_o)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (!xfer_valid_o && !dma_gnt_o && !desc_rd_o));
  assert_ignore_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cb_wr_i && state_q == ST_XFER) |=> next_ptr == $past(next_ptr));
  assert_gnt_paced_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o |-> paced_q);
  assert_chain_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_end && chain_last) |=> !active_o);
endmodule

// File: tb/dma_chain_ctrl_tb.sv
module dma_chain_ctrl_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          cb_wr = 0, cb_paced = 0, cb_every = 0;
  logic [AW-1:0] cb_addr = '0, cb_mod = '0, cb_cnt = '0, cb_next = '0;
  logic          active, xvalid, xready = 1'b1, req = 1'b0, gnt;
  logic          drd, irq;
  logic [AW-1:0] xaddr, daddr, ddata;
  logic [AW-1:0] mem [16];

  assign ddata = mem[daddr[3:0]];

  dma_chain_ctrl #(.AW(AW), .CRW(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cb_wr_i(cb_wr), .cb_addr_i(cb_addr), .cb_mod_i(cb_mod), .cb_cnt_i(cb_cnt),
    .cb_next_i(cb_next), .cb_paced_i(cb_paced), .cb_irq_every_i(cb_every),
    .active_o(active), .xfer_valid_o(xvalid), .xfer_addr_o(xaddr),
    .xfer_ready_i(xready), .dma_req_i(req), .dma_gnt_o(gnt),
    .desc_rd_o(drd), .desc_addr_o(daddr), .desc_ack_i(drd), .desc_data_i(ddata),
    .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // monitor, cumulative logs
  logic [AW-1:0] acc_log [256];
  logic [AW-1:0] desc_log [64];
  int acc_n = 0, irq_n = 0, desc_n = 0, gnt_bad = 0;
  bit paced_tb = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (xvalid && xready) begin
        acc_log[acc_n % 256] <= xaddr;
        acc_n <= acc_n + 1;
        if (paced_tb && !gnt) gnt_bad <= gnt_bad + 1;
      end
      if (!paced_tb && gnt) gnt_bad <= gnt_bad + 1;
      if (irq) irq_n <= irq_n + 1;
      if (drd) begin
        desc_log[desc_n % 64] <= daddr;
        desc_n <= desc_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask

  task automatic load_cb(input logic [AW-1:0] a, input logic [AW-1:0] m,
                         input logic [AW-1:0] c, input logic [AW-1:0] n,
                         input bit p, input bit e);
    drive_edge();
    cb_addr = a; cb_mod = m; cb_cnt = c; cb_next = n;
    cb_paced = p; cb_every = e; cb_wr = 1'b1;
    drive_edge();
    cb_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (!active) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_req(input int hi, input int lo);
    drive_edge(); req = 1'b1;
    repeat (hi) drive_edge();
    req = 1'b0;
    repeat (lo - 1) drive_edge();
  endtask

  // vector table: start, stride, count (single blocks, R3/R4/R6/R8)
  localparam int NV = 4;
  localparam logic [31:0] V_ADDR [NV] = '{32'h40, 32'h80, 32'h10, 32'hC0};
  localparam int          V_MOD  [NV] = '{1, -2, 4, 8};
  localparam int          V_CNT  [NV] = '{4, 3, 0, 6};

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    int b_acc, b_irq, b_desc, b_gnt;
    logic [AW-1:0] exp_a;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[4] = 32'h100; mem[5] = 32'd2; mem[6] = 32'd3; mem[7] = 32'd8;
    mem[8] = 32'h200; mem[9] = 32'hFFFF_FFFF; mem[10] = 32'd2; mem[11] = 32'd0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!active, "R1", "active_o", active, 0);
    chk(!xvalid, "R1", "xfer_valid_o", xvalid, 0);
    chk(!gnt,    "R1", "dma_gnt_o", gnt, 0);
    chk(!drd,    "R1", "desc_rd_o", drd, 0);
    chk(!irq,    "R1", "irq_o", irq, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      b_acc = acc_n; b_irq = irq_n;
      load_cb(V_ADDR[v], AW'(V_MOD[v]), AW'(V_CNT[v]), '0, 1'b0, 1'b0);
      if (v == 0) begin
        // R2: one cycle after the write edge
        @(negedge clk);
        chk(active, "R2", "active_o after load", active, 1);
      end
      wait_idle();
      chk(acc_n - b_acc == V_CNT[v], V_CNT[v] == 0 ? "R4" : "R3",
          "word count", acc_n - b_acc, V_CNT[v]);
      for (int k = 0; k < V_CNT[v]; k++) begin
        exp_a = V_ADDR[v] + AW'(k * V_MOD[v]);
        chk(acc_log[(b_acc + k) % 256] == exp_a, "R3", "word address",
            acc_log[(b_acc + k) % 256], exp_a);
      end
      chk(irq_n - b_irq == 1, "R6", "irq pulses", irq_n - b_irq, 1);
      chk(!active, "R8", "active_o after chain end", active, 0);
    end
    // R2: first address equals written start (table entry 0)
    chk(acc_log[0] == 32'h40, "R2", "first address", acc_log[0], 32'h40);

    // R5: write while active is ignored
    b_acc = acc_n;
    drive_edge(); xready = 1'b0;
    load_cb(32'h500, 32'd1, 32'd2, '0, 1'b0, 1'b0);
    load_cb(32'h900, 32'd3, 32'd5, '0, 1'b0, 1'b0);
    drive_edge(); xready = 1'b1;
    wait_idle();
    chk(acc_n - b_acc == 2, "R5", "words after ignored write", acc_n - b_acc, 2);
    chk(acc_log[b_acc % 256] == 32'h500, "R5", "addr0", acc_log[b_acc % 256], 32'h500);
    chk(acc_log[(b_acc + 1) % 256] == 32'h501, "R5", "addr1",
        acc_log[(b_acc + 1) % 256], 32'h501);

    // R7: chain with irq at every block
    b_acc = acc_n; b_irq = irq_n; b_desc = desc_n;
    load_cb(32'h300, 32'd1, 32'd2, 32'd4, 1'b0, 1'b1);
    wait_idle();
    chk(acc_n - b_acc == 7, "R7", "chained words", acc_n - b_acc, 7);
    begin
      logic [AW-1:0] ea [7];
      ea = '{32'h300, 32'h301, 32'h100, 32'h102, 32'h104, 32'h200, 32'h1FF};
      for (int k = 0; k < 7; k++)
        chk(acc_log[(b_acc + k) % 256] == ea[k], "R7", "chained address",
            acc_log[(b_acc + k) % 256], ea[k]);
    end
    chk(desc_n - b_desc == 8, "R7", "descriptor reads", desc_n - b_desc, 8);
    for (int k = 0; k < 8; k++)
      chk(desc_log[(b_desc + k) % 64] == AW'(4 + k), "R7", "descriptor read order",
          desc_log[(b_desc + k) % 64], 4 + k);
    chk(irq_n - b_irq == 3, "R6", "irq every block", irq_n - b_irq, 3);

    // R6: same chain, irq only at chain end
    b_irq = irq_n; b_acc = acc_n;
    load_cb(32'h300, 32'd1, 32'd2, 32'd4, 1'b0, 1'b0);
    wait_idle();
    chk(irq_n - b_irq == 1, "R6", "irq at chain end only", irq_n - b_irq, 1);
    chk(acc_n - b_acc == 7, "R8", "chain completes", acc_n - b_acc, 7);

    // R9: paced, credit from held-off edges
    paced_tb = 1;
    b_acc = acc_n; b_irq = irq_n; b_gnt = gnt_bad;
    load_cb(32'h700, 32'd1, 32'd3, '0, 1'b1, 1'b0);
    repeat (8) drive_edge();
    chk(acc_n - b_acc == 0, "R9", "no word without request", acc_n - b_acc, 0);
    chk(!gnt, "R9", "grant low without request", gnt, 0);
    pulse_req(3, 3);
    repeat (8) drive_edge();
    chk(acc_n - b_acc == 1, "R9", "one word per edge", acc_n - b_acc, 1);
    xready = 1'b0;
    pulse_req(3, 3);
    pulse_req(3, 3);
    repeat (6) drive_edge();
    chk(acc_n - b_acc == 1, "R9", "held while not ready", acc_n - b_acc, 1);
    xready = 1'b1;
    wait_idle();
    chk(acc_n - b_acc == 3, "R9", "queued edges kept", acc_n - b_acc, 3);
    chk(irq_n - b_irq == 1, "R9", "paced block irq", irq_n - b_irq, 1);

    // R9: edges overlapping acceptances
    b_acc = acc_n;
    load_cb(32'h780, 32'd2, 32'd4, '0, 1'b1, 1'b0);
    for (int k = 0; k < 6; k++) pulse_req(2, 2);
    wait_idle();
    chk(acc_n - b_acc == 4, "R9", "overlapped edges word total", acc_n - b_acc, 4);
    chk(gnt_bad == b_gnt, "R9", "grant at every paced word", gnt_bad - b_gnt, 0);
    paced_tb = 0;

    // R10: unpaced ignores request
    b_acc = acc_n; b_gnt = gnt_bad;
    load_cb(32'hA00, 32'd1, 32'd5, '0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) pulse_req(1, 1);
    wait_idle();
    chk(acc_n - b_acc == 5, "R10", "unpaced words", acc_n - b_acc, 5);
    chk(gnt_bad == b_gnt, "R10", "grant stays low", gnt_bad - b_gnt, 0);

    summary();
  end
endmodule